// File: doc/BRIEF.md
# Telecom Serial Bus Frame Timer

This block produces the timing for a 2.048 Mbit/s time-division serial bus frame. It runs on a 4.096 MHz master clock and takes an active-low frame pulse. From these it makes a half-rate bit clock, two channel enable strobes, a delayed frame pulse, and bit and channel position counters. Serial ports further down the chip use these to shift their data in and out.

A select input chooses between two output timing schemes. In companded mode the two strobes each mark one 8-bit channel timeslot. In linear mode the first strobe becomes a single-bit marker at the end of the frame, and the second strobe is released. The block also watches the health of the frame pulse. A pulse that stays low too long stops the timebase. A frame that ends without a pulse silences the strobes but lets the bit clock keep running.

An output-enable flag stands in for the pin that would be driven to high impedance. The block does no data shifting or coding.

Top module: `fts_frame_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first valid frame pulse, every output is idle: `bclk_o`, both strobes and `strb_b_oe_o` are 0, `dly_frm_n_o` is 1, and both position outputs are 0.
- R2: While the timebase runs, `bclk_o` is 1 in even frame cycles and 0 in odd frame cycles. Each bit period spans two master cycles and starts with the high half.
- R3: A valid frame pulse is `frm_n_i` sampled low on one or two consecutive rising edges and then sampled high. Call the edge that samples it high E. Registers set at E show frame cycle 0 after edge E+1. A frame is 512 master cycles, and `bit_idx_o` equals the frame cycle divided by two (0..255).
- R4: In companded mode (`lin_mode_i` = 0) with a frame locked, `strb_a_o` is 1 for bit periods 16..23 (channel 2). `strb_b_o` is 1 for bit periods 24..31 (channel 3). The two are never 1 together.
- R5: In linear mode (`lin_mode_i` = 1), `strb_a_o` is 1 only during bit period 255, and `strb_b_o` and `strb_b_oe_o` are 0. In companded mode, `strb_b_oe_o` is 1 whenever the timebase runs.
- R6: With a frame locked, `dly_frm_n_o` is 0 for frame cycles 64 and 65 in companded mode, and for frame cycles 128 and 129 in linear mode. It is 1 at all other times.
- R7: `chan_idx_o` equals `bit_idx_o` divided by 8 (0..31).
- R8: A third consecutive low sample of `frm_n_i` stops the timebase. From the next output update, `bclk_o` stays 0, the strobes stay idle and the positions stay 0, until a valid frame pulse is seen.
- R9: If frame cycle 511 passes without a valid pulse ending there, the strobes and the delayed pulse stay inactive until the next valid pulse.
- R10: With `frm_n_i` held high, the bit clock and the position counters keep running, and the frame cycle wraps from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 4.096 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset (power-down) |
| frm_n_i | input | 1 | Active-low frame pulse |
| lin_mode_i | input | 1 | 1 = linear timing scheme, 0 = companded |
| bclk_o | output | 1 | Half-rate bit clock |
| strb_a_o | output | 1 | First channel enable strobe |
| strb_b_o | output | 1 | Second channel enable strobe |
| strb_b_oe_o | output | 1 | Drive enable for the second strobe |
| dly_frm_n_o | output | 1 | Active-low delayed frame pulse |
| bit_idx_o | output | 8 | Bit period within the frame |
| chan_idx_o | output | 5 | Channel (8-bit timeslot) within the frame |

## Verification
The bench applies one-cycle and two-cycle frame pulses, which must lock, and three-cycle and four-cycle pulses, which must stop the timebase. A detector that is off by one would either accept a stuck line or reject a legal short pulse. Frames with no pulse, and runs with the pulse held high, check that the strobes go quiet while the bit clock keeps running. A design that tied the two together would either freeze the clock or keep strobing with no reference. The mode is switched at frame boundaries, so the bit-255 marker, the released second strobe and the 64- and 128-cycle delayed-pulse positions are each checked. An error of one master cycle in any of these shows up as a miscompare on that cycle.

// File: rtl/fts_pkg.sv
package fts_pkg;

    // Classification of the frame pulse line at one master-clock edge
    typedef enum logic [1:0] {
        FP_NONE  = 2'd0,
        FP_VALID = 2'd1,
        FP_STUCK = 2'd2
    } fp_evt_e;

endpackage

// File: rtl/fts_pulse_det.sv
module fts_pulse_det #(
    parameter int PULSE_MAX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_n_i,
    output fts_pkg::fp_evt_e evt_o
);
    import fts_pkg::*;

    localparam int              RUN_W   = $clog2(PULSE_MAX + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PULSE_MAX);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(PULSE_MAX + 1);

    typedef struct packed {
        logic [RUN_W-1:0] low_run;
    } det_s;

    det_s    st_d, st_q;
    fp_evt_e evt;

    always_comb begin
        st_d = st_q;
        evt  = FP_NONE;
        if (!frm_n_i) begin
            // a low sample beyond the allowed width means a stuck line
            if (st_q.low_run >= RUN_MAX) begin
                evt = FP_STUCK;
            end
            if (st_q.low_run != RUN_SAT) begin
                st_d.low_run = st_q.low_run + 1'b1;
            end
        end else begin
            // pulse end: accept only 1..PULSE_MAX low samples
            if ((st_q.low_run != '0) && (st_q.low_run <= RUN_MAX)) begin
                evt = FP_VALID;
            end
            st_d.low_run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = evt;

endmodule

// File: rtl/fts_timebase.sv
module fts_timebase #(
    parameter int FRAME_CYC = 512,
    localparam int CYC_W    = $clog2(FRAME_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fts_pkg::fp_evt_e evt_i,
    output logic [CYC_W-1:0] cyc_o,
    output logic             run_o,
    output logic             lock_o
);
    import fts_pkg::*;

    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(FRAME_CYC - 1);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic             run;
        logic             lock;
    } tb_s;

    tb_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (evt_i)
            FP_VALID: begin
                st_d.cyc  = '0;
                st_d.run  = 1'b1;
                st_d.lock = 1'b1;
            end
            FP_STUCK: begin
                st_d = '0;
            end
            default: begin
                if (st_q.run) begin
                    if (st_q.cyc == CYC_LAST) begin
                        // frame over with no pulse: keep counting, drop lock
                        st_d.cyc  = '0;
                        st_d.lock = 1'b0;
                    end else begin
                        st_d.cyc = st_q.cyc + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_o  = st_q.cyc;
    assign run_o  = st_q.run;
    assign lock_o = st_q.lock;

endmodule

// File: rtl/fts_strobe_gen.sv
module fts_strobe_gen #(
    parameter int FRAME_BITS    = 256,
    parameter int BITS_PER_CHAN = 8,
    parameter int CH_A          = 2,
    parameter int CH_B          = 3,
    parameter int DLY_CMP       = 64,
    parameter int DLY_LIN       = 128,
    localparam int CYC_W        = $clog2(2 * FRAME_BITS),
    localparam int BIT_W        = $clog2(FRAME_BITS),
    localparam int SUB_W        = $clog2(BITS_PER_CHAN),
    localparam int CHAN_W       = BIT_W - SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CYC_W-1:0]  cyc_i,
    input  logic              run_i,
    input  logic              lock_i,
    input  logic              lin_i,
    output logic              bclk_o,
    output logic              strb_a_o,
    output logic              strb_b_o,
    output logic              strb_b_oe_o,
    output logic              dly_n_o,
    output logic [BIT_W-1:0]  bit_o,
    output logic [CHAN_W-1:0] chan_o
);
    localparam logic [CYC_W-1:0] DC0      = CYC_W'(DLY_CMP);
    localparam logic [CYC_W-1:0] DC1      = CYC_W'(DLY_CMP + 1);
    localparam logic [CYC_W-1:0] DL0      = CYC_W'(DLY_LIN);
    localparam logic [CYC_W-1:0] DL1      = CYC_W'(DLY_LIN + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = '1;
    localparam int               N_STRB   = 2;

    typedef struct packed {
        logic              bclk;
        logic              strb_a;
        logic              strb_b;
        logic              strb_b_oe;
        logic              dly_n;
        logic [BIT_W-1:0]  bit_idx;
        logic [CHAN_W-1:0] chan_idx;
    } out_s;

    out_s              out_d, out_q;
    logic [BIT_W-1:0]  bit_w;
    logic [CHAN_W-1:0] chan_w;
    logic [N_STRB-1:0] slot_hit;

    assign bit_w  = cyc_i[CYC_W-1:1];
    assign chan_w = bit_w[BIT_W-1:SUB_W];

    // one timeslot comparator per companded strobe
    for (genvar gi = 0; gi < N_STRB; gi++) begin : g_slot
        localparam logic [CHAN_W-1:0] SLOT = CHAN_W'((gi == 0) ? CH_A : CH_B);
        assign slot_hit[gi] = (chan_w == SLOT);
    end

    always_comb begin
        logic dly_hit;
        out_d          = out_q;
        out_d.bclk     = run_i & ~cyc_i[0];
        out_d.bit_idx  = bit_w;
        out_d.chan_idx = chan_w;
        if (lin_i) begin
            out_d.strb_a    = lock_i & (bit_w == LAST_BIT);
            out_d.strb_b    = 1'b0;
            out_d.strb_b_oe = 1'b0;
            dly_hit         = (cyc_i == DL0) || (cyc_i == DL1);
        end else begin
            out_d.strb_a    = lock_i & slot_hit[0];
            out_d.strb_b    = lock_i & slot_hit[1];
            out_d.strb_b_oe = run_i;
            dly_hit         = (cyc_i == DC0) || (cyc_i == DC1);
        end
        out_d.dly_n = ~(lock_i & dly_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q       <= '0;
            out_q.dly_n <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign bclk_o      = out_q.bclk;
    assign strb_a_o    = out_q.strb_a;
    assign strb_b_o    = out_q.strb_b;
    assign strb_b_oe_o = out_q.strb_b_oe;
    assign dly_n_o     = out_q.dly_n;
    assign bit_o       = out_q.bit_idx;
    assign chan_o      = out_q.chan_idx;

endmodule

// File: rtl/fts_frame_timer.sv
module fts_frame_timer #(
    parameter int FRAME_BITS    = 256,
    parameter int BITS_PER_CHAN = 8,
    parameter int CH_A          = 2,
    parameter int CH_B          = 3,
    parameter int DLY_CMP       = 64,
    parameter int DLY_LIN       = 128,
    parameter int PULSE_MAX     = 2
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           frm_n_i,
    input  logic                                           lin_mode_i,
    output logic                                           bclk_o,
    output logic                                           strb_a_o,
    output logic                                           strb_b_o,
    output logic                                           strb_b_oe_o,
    output logic                                           dly_frm_n_o,
    output logic [$clog2(FRAME_BITS)-1:0]                  bit_idx_o,
    output logic [$clog2(FRAME_BITS/BITS_PER_CHAN)-1:0]    chan_idx_o
);
    import fts_pkg::*;

    localparam int FRAME_CYC = 2 * FRAME_BITS;
    localparam int CYC_W     = $clog2(FRAME_CYC);

    fp_evt_e          evt;
    logic [CYC_W-1:0] cyc;
    logic             run;
    logic             lock;

    fts_pulse_det #(
        .PULSE_MAX (PULSE_MAX)
    ) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .frm_n_i (frm_n_i),
        .evt_o   (evt)
    );

    fts_timebase #(
        .FRAME_CYC (FRAME_CYC)
    ) u_tbase (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .cyc_o  (cyc),
        .run_o  (run),
        .lock_o (lock)
    );

    fts_strobe_gen #(
        .FRAME_BITS    (FRAME_BITS),
        .BITS_PER_CHAN (BITS_PER_CHAN),
        .CH_A          (CH_A),
        .CH_B          (CH_B),
        .DLY_CMP       (DLY_CMP),
        .DLY_LIN       (DLY_LIN)
    ) u_strb (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_i       (cyc),
        .run_i       (run),
        .lock_i      (lock),
        .lin_i       (lin_mode_i),
        .bclk_o      (bclk_o),
        .strb_a_o    (strb_a_o),
        .strb_b_o    (strb_b_o),
        .strb_b_oe_o (strb_b_oe_o),
        .dly_n_o     (dly_frm_n_o),
        .bit_o       (bit_idx_o),
        .chan_o      (chan_idx_o)
    );

endmodule

// File: rtl/fts_frame_timer_chk.sv
module fts_frame_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic frm_n_i,
    input logic bclk_o,
    input logic strb_a_o,
    input logic strb_b_o,
    input logic strb_b_oe_o,
    input logic dly_frm_n_o
);
    // edges seen since reset release, saturating
    logic [2:0] since_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q != 3'd7) begin
            since_rst_q <= since_rst_q + 1'b1;
        end
    end

    AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(strb_a_o && strb_b_o)); // R4

    AST_BCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_o |=> !bclk_o); // R2

    AST_STUCK_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q >= 3'd4 && !$past(frm_n_i, 1) && !$past(frm_n_i, 2)
         && !$past(frm_n_i, 3)) |=> !bclk_o); // R8

    AST_DLY_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dly_frm_n_o) |=> !dly_frm_n_o); // R6

    AST_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_b_oe_o |-> !strb_b_o); // R5

endmodule

bind fts_frame_timer fts_frame_timer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_n_i     (frm_n_i),
    .bclk_o      (bclk_o),
    .strb_a_o    (strb_a_o),
    .strb_b_o    (strb_b_o),
    .strb_b_oe_o (strb_b_oe_o),
    .dly_frm_n_o (dly_frm_n_o)
);

// File: tb/fts_frame_timer_tb_top.sv
module fts_frame_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frm_n;
    logic       lin;
    logic       bclk, strb_a, strb_b, strb_b_oe, dly_n;
    logic [7:0] bit_idx;
    logic [4:0] chan_idx;

    always #2 clk = ~clk;

    fts_frame_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_n_i     (frm_n),
        .lin_mode_i  (lin),
        .bclk_o      (bclk),
        .strb_a_o    (strb_a),
        .strb_b_o    (strb_b),
        .strb_b_oe_o (strb_b_oe),
        .dly_frm_n_o (dly_n),
        .bit_idx_o   (bit_idx),
        .chan_idx_o  (chan_idx)
    );

    int    vec_cnt  = 0;
    int    miss_cnt = 0;
    bit    done     = 1'b0;
    bit    chk_en   = 1'b0;
    string phase    = "R1";

    // reference state built from the requirements
    int m_cyc, m_lr, ev;
    bit m_run, m_lock;
    int e_bclk, e_a, e_b, e_oe, e_dly, e_bit, e_chan;

    function automatic int f_bclk(bit run, int cyc);
        return (run && (cyc % 2 == 0)) ? 1 : 0;
    endfunction

    function automatic int f_strb_a(bit lk, bit ln, int cyc);
        if (!lk) return 0;
        if (ln) return ((cyc / 2) == 255) ? 1 : 0;
        return ((cyc / 16) == 2) ? 1 : 0;
    endfunction

    function automatic int f_strb_b(bit lk, bit ln, int cyc);
        return (lk && !ln && (cyc / 16) == 3) ? 1 : 0;
    endfunction

    function automatic int f_dly_n(bit lk, bit ln, int cyc);
        int d;
        d = ln ? 128 : 64;
        return (lk && (cyc == d || cyc == d + 1)) ? 0 : 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cyc = 0; m_lr = 0; m_run = 0; m_lock = 0;
            e_bclk = 0; e_a = 0; e_b = 0; e_oe = 0; e_dly = 1;
            e_bit = 0; e_chan = 0;
        end else begin
            e_bclk = f_bclk(m_run, m_cyc);
            e_bit  = m_cyc / 2;
            e_chan = m_cyc / 16;
            e_a    = f_strb_a(m_lock, lin, m_cyc);
            e_b    = f_strb_b(m_lock, lin, m_cyc);
            e_oe   = (m_run && !lin) ? 1 : 0;
            e_dly  = f_dly_n(m_lock, lin, m_cyc);
            ev = 0;
            if (!frm_n) begin
                if (m_lr >= 2) ev = 2;
                if (m_lr < 3) m_lr = m_lr + 1;
            end else begin
                if (m_lr >= 1 && m_lr <= 2) ev = 1;
                m_lr = 0;
            end
            if (ev == 1) begin
                m_cyc = 0; m_run = 1; m_lock = 1;
            end else if (ev == 2) begin
                m_cyc = 0; m_run = 0; m_lock = 0;
            end else if (m_run) begin
                if (m_cyc == 511) begin
                    m_cyc = 0; m_lock = 0;
                end else begin
                    m_cyc = m_cyc + 1;
                end
            end
        end
        chk_en = 1'b1;
    end

    task automatic cmp(string tag, string name, int act, int exp);
        if (act != exp) begin
            miss_cnt++;
            $display("FAIL %s (%s) %s: actual=%0d expected=%0d at %0t",
                     tag, phase, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            vec_cnt++;
            if (phase == "R1") begin
                cmp("R1", "bclk", int'(bclk), e_bclk);
                cmp("R1", "dly_n", int'(dly_n), e_dly);
                cmp("R1", "strb_b_oe", int'(strb_b_oe), e_oe);
            end else begin
                cmp("R2", "bclk", int'(bclk), e_bclk);
                cmp("R6", "dly_n", int'(dly_n), e_dly);
                cmp("R5", "strb_b_oe", int'(strb_b_oe), e_oe);
            end
            cmp("R3", "bit_idx", int'(bit_idx), e_bit);
            cmp("R7", "chan_idx", int'(chan_idx), e_chan);
            cmp(lin ? "R5" : "R4", "strb_a", int'(strb_a), e_a);
            cmp(lin ? "R5" : "R4", "strb_b", int'(strb_b), e_b);
        end
    end

    task automatic step(bit v);
        @(negedge clk);
        frm_n = v;
    endtask

    // one 512-cycle frame ending with an L-cycle low pulse
    task automatic frame(int len, bit ln);
        @(negedge clk);
        lin   = ln;
        frm_n = 1'b1;
        repeat (510 - len) step(1'b1);
        repeat (len) step(1'b0);
        step(1'b1);
    endtask

    initial begin
        int unsigned r;
        int          plen;
        r     = $urandom(32'd7331);
        rst_n = 1'b0;
        frm_n = 1'b1;
        lin   = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (40) step(1'b1);          // R1: idle until first pulse
        phase = "R3";
        step(1'b0); step(1'b0); step(1'b1);
        phase = "R4";
        repeat (2) frame(2, 1'b0);
        phase = "R5";
        frame(2, 1'b1);
        phase = "R6";
        frame(2, 1'b1);
        frame(2, 1'b0);
        phase = "R3";
        frame(1, 1'b0);                  // single-cycle pulse still locks
        phase = "R9";
        frame(0, 1'b0);                  // missing pulse
        phase = "R10";
        frame(0, 1'b0);
        frame(0, 1'b1);
        phase = "R3";
        frame(2, 1'b0);
        phase = "R8";
        frame(4, 1'b0);                  // stuck low
        frame(3, 1'b1);
        phase = "R3";
        frame(2, 1'b0);
        frame(2, 1'b1);
        phase = "R7";
        for (int i = 0; i < 30; i++) begin
            r = $urandom % 8;
            if (r < 5)       plen = 2;
            else if (r == 5) plen = 1;
            else if (r == 6) plen = 0;
            else             plen = 3 + int'($urandom % 2);
            frame(plen, 1'($urandom % 2));
        end
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end

    initial begin
        #(100000 * 4);
        if (!done) begin
            done = 1'b1;
            miss_cnt++;
            $display("FAIL R3 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
            $finish;
        end
    end

endmodule